// File: doc/BRIEF.md
# Tagged Operand Matching Stage

This block sits at the front of a data-driven processing element. Operand tokens arrive on a valid/ready input. Each token carries a data value, a tag naming the instruction it feeds, the operand slot it fills (0 or 1), and a bit that says whether the target instruction takes one operand or two. There is no program counter. An instruction fires as soon as its operands are present, so packets leave in the order in which operand sets complete.

A token for a one-operand instruction fires at once. A token for a two-operand instruction is checked against a 16-entry waiting store, which is searched by tag:
- If the store holds no entry for that tag, the token waits in a free entry.
- If the store holds the partner token for the other slot, the pair fires as one packet and the entry is freed. The operand is consumed and cannot be matched again.
- If the store already holds a token for the same slot of that tag, the new token is a protocol error. It is dropped and flagged.

Fired packets go out through a single output register, which holds its contents while the consumer stalls.

Top module: `token_match_unit`

## Requirements
- R1: After reset, `outValid` is 0, `errDrop` is 0, `inReady` is 1 and the waiting store is empty.
- R2: A token accepted with `inTwo`=0 fires on the next clock edge. The packet has `outTag` equal to the token tag, `outOp0` equal to the token data, `outOp1`=0 and `outPair`=0. The `inPort` value has no effect.
- R3: A token accepted with `inTwo`=1 whose tag has no waiting entry is stored, and no packet is produced for it.
- R4: A token accepted with `inTwo`=1 whose tag has a waiting entry for the other slot fires on the next edge with `outPair`=1. `outOp0` carries the slot-0 value and `outOp1` carries the slot-1 value, whichever of the two arrived first.
- R5: Firing frees the entry. A later slot-0 token with the same tag is stored afresh and waits for a new partner.
- R6: A token for a slot that is already waiting under the same tag is accepted and dropped. `errDrop` is 1 for exactly the cycle after it is accepted, no packet is produced, and the stored value is kept.
- R7: Waiting tokens with different tags are held apart. Packets leave in the order in which their second operand arrives, not in the order of the first.
- R8: When all 16 entries are occupied, `inReady` is 0 for a two-operand token whose tag has no waiting entry. It stays 1 for a token that matches a waiting entry.
- R9: While `outValid` is 1 and `outReady` is 0, the packet stays unchanged and `inReady` is 0.
- R10: With `outReady` held at 1 and space in the store, one token is accepted on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Reset, active low, synchronous |
| inValid | input | 1 | Input token present |
| inReady | output | 1 | Input token accepted on this edge when valid |
| inTag | input | TAG_W | Destination instruction tag |
| inPort | input | 1 | Operand slot: 0 or 1 |
| inTwo | input | 1 | 1: instruction takes two operands; 0: one operand |
| inData | input | DATA_W | Operand value |
| outValid | output | 1 | Fired packet present |
| outReady | input | 1 | Consumer takes the packet on this edge when valid |
| outTag | output | TAG_W | Tag of the fired instruction |
| outOp0 | output | DATA_W | Operand for slot 0 |
| outOp1 | output | DATA_W | Operand for slot 1 (0 for one-operand packets) |
| outPair | output | 1 | 1 when the packet carries two operands |
| errDrop | output | 1 | One-cycle pulse: a duplicate-slot token was dropped |

## Verification
A firing packet appears on the output exactly one edge after the token that completes it is accepted. `errDrop` rises on that same edge after a duplicate. A stored token produces nothing at all.

The driver waits for the accepting edge and then samples `errDrop` and `outValid` one time unit after it. A scoreboard queue receives each expected packet before its trigger token is sent. A monitor compares packets at the falling edge whenever `outValid` and `outReady` are both high, so order and contents are checked on the cycle of each transfer. Any packet that arrives without a queued expectation counts as a failure.

// File: rtl/tmu_pkg.sv
package tmu_pkg;

  // strobes from control to datapath, one decision per cycle
  typedef struct packed {
    logic take;        // input token accepted this edge
    logic fireSingle;  // one-operand instruction fires
    logic fireMatch;   // waiting partner found, pair fires
    logic alloc;       // token written into a free entry
    logic dropDup;     // duplicate slot, token discarded
    logic outDrain;    // consumer takes the output packet
  } tmuStrobe_t;

endpackage

// File: rtl/tmu_slot.sv
module tmu_slot #(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setEn,
  input  logic              clrEn,
  input  logic [TAG_W-1:0]  setTag,
  input  logic              setPort,
  input  logic [DATA_W-1:0] setData,
  input  logic [TAG_W-1:0]  lookTag,
  output logic              slotValid,
  output logic              slotHit,
  output logic              slotPort,
  output logic [DATA_W-1:0] slotData
);

  logic [TAG_W-1:0] tagQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid <= 1'b0;
      tagQ      <= '0;
      slotPort  <= 1'b0;
      slotData  <= '0;
    end else if (setEn) begin
      slotValid <= 1'b1;
      tagQ      <= setTag;
      slotPort  <= setPort;
      slotData  <= setData;
    end else if (clrEn) begin
      slotValid <= 1'b0;
    end
  end

  assign slotHit = slotValid && (tagQ == lookTag);

endmodule

// File: rtl/tmu_control.sv
module tmu_control
  import tmu_pkg::*;
(
  input  logic       inValid,
  input  logic       inTwo,
  input  logic       hitAny,
  input  logic       hitSamePort,
  input  logic       storeFull,
  input  logic       outValid,
  input  logic       outReady,
  output logic       inReady,
  output tmuStrobe_t strobe
);

  logic roomOut;
  logic needsSlot;

  always_comb begin
    roomOut   = !outValid || outReady;
    needsSlot = inTwo && !hitAny;
    // a token that needs no new entry may enter a full store
    inReady   = roomOut && (!storeFull || (inValid && !needsSlot));

    strobe.take       = inValid && inReady;
    strobe.fireSingle = strobe.take && !inTwo;
    strobe.fireMatch  = strobe.take && inTwo && hitAny && !hitSamePort;
    strobe.dropDup    = strobe.take && inTwo && hitAny && hitSamePort;
    strobe.alloc      = strobe.take && needsSlot;
    strobe.outDrain   = outValid && outReady;
  end

endmodule

// File: rtl/tmu_datapath.sv
module tmu_datapath
  import tmu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 6,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmuStrobe_t        strobe,
  input  logic [TAG_W-1:0]  inTag,
  input  logic              inPort,
  input  logic [DATA_W-1:0] inData,
  output logic              hitAny,
  output logic              hitSamePort,
  output logic              storeFull,
  output logic [DEPTH-1:0]  hitVec,
  output logic              outValid,
  output logic [TAG_W-1:0]  outTag,
  output logic [DATA_W-1:0] outOp0,
  output logic [DATA_W-1:0] outOp1,
  output logic              outPair,
  output logic              errDrop
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  validVec;
  logic [DEPTH-1:0]  portVec;
  logic [DATA_W-1:0] dataArr [DEPTH];
  logic [DEPTH-1:0]  setVec;
  logic [DEPTH-1:0]  clrVec;
  logic [IDX_W-1:0]  freeIdx;
  logic              freeFound;
  logic [DATA_W-1:0] hitData;
  logic              hitPort;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : gSlot
      assign setVec[g] = strobe.alloc && (freeIdx == IDX_W'(g));
      assign clrVec[g] = strobe.fireMatch && hitVec[g];
      tmu_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W)) uSlot (
        .clk      (clk),
        .rstN     (rstN),
        .setEn    (setVec[g]),
        .clrEn    (clrVec[g]),
        .setTag   (inTag),
        .setPort  (inPort),
        .setData  (inData),
        .lookTag  (inTag),
        .slotValid(validVec[g]),
        .slotHit  (hitVec[g]),
        .slotPort (portVec[g]),
        .slotData (dataArr[g])
      );
    end
  endgenerate

  // lowest free entry wins the allocation
  always_comb begin
    freeIdx   = '0;
    freeFound = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!validVec[i] && !freeFound) begin
        freeIdx   = IDX_W'(i);
        freeFound = 1'b1;
      end
    end
  end

  // at most one entry per tag, so an OR of gated values is a clean mux
  always_comb begin
    hitData = '0;
    hitPort = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      hitData = hitData | (hitVec[i] ? dataArr[i] : '0);
      hitPort = hitPort | (hitVec[i] & portVec[i]);
    end
  end

  assign hitAny      = |hitVec;
  assign hitSamePort = hitAny && (hitPort == inPort);
  assign storeFull   = &validVec;

  // output register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outTag   <= '0;
      outOp0   <= '0;
      outOp1   <= '0;
      outPair  <= 1'b0;
      errDrop  <= 1'b0;
    end else begin
      errDrop <= strobe.dropDup;
      if (strobe.fireSingle) begin
        outValid <= 1'b1;
        outTag   <= inTag;
        outOp0   <= inData;
        outOp1   <= '0;
        outPair  <= 1'b0;
      end else if (strobe.fireMatch) begin
        outValid <= 1'b1;
        outTag   <= inTag;
        outOp0   <= inPort ? hitData : inData;
        outOp1   <= inPort ? inData : hitData;
        outPair  <= 1'b1;
      end else if (strobe.outDrain) begin
        outValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/token_match_unit.sv
module token_match_unit
  import tmu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 6,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [TAG_W-1:0]  inTag,
  input  logic              inPort,
  input  logic              inTwo,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [TAG_W-1:0]  outTag,
  output logic [DATA_W-1:0] outOp0,
  output logic [DATA_W-1:0] outOp1,
  output logic              outPair,
  output logic              errDrop
);

  tmuStrobe_t       strobe;
  logic             hitAny;
  logic             hitSamePort;
  logic             storeFull;
  logic [DEPTH-1:0] hitVec;

  tmu_control uCtrl (
    .inValid    (inValid),
    .inTwo      (inTwo),
    .hitAny     (hitAny),
    .hitSamePort(hitSamePort),
    .storeFull  (storeFull),
    .outValid   (outValid),
    .outReady   (outReady),
    .inReady    (inReady),
    .strobe     (strobe)
  );

  tmu_datapath #(.DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(DEPTH)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inTag      (inTag),
    .inPort     (inPort),
    .inData     (inData),
    .hitAny     (hitAny),
    .hitSamePort(hitSamePort),
    .storeFull  (storeFull),
    .hitVec     (hitVec),
    .outValid   (outValid),
    .outTag     (outTag),
    .outOp0     (outOp0),
    .outOp1     (outOp1),
    .outPair    (outPair),
    .errDrop    (errDrop)
  );

endmodule

// File: rtl/tmu_checker.sv
module tmu_checker #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 6,
  parameter int DEPTH  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [TAG_W-1:0]  inTag,
  input logic              inTwo,
  input logic [DATA_W-1:0] inData,
  input logic              outValid,
  input logic              outReady,
  input logic [TAG_W-1:0]  outTag,
  input logic [DATA_W-1:0] outOp0,
  input logic [DATA_W-1:0] outOp1,
  input logic              outPair,
  input logic              errDrop,
  input logic              storeFull,
  input logic [DEPTH-1:0]  hitVec
);

  a_r2_single_fires: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && !inTwo |=>
      outValid && !outPair && outTag == $past(inTag) && outOp0 == $past(inData));

  a_r6_err_after_pair_token: assert property (@(posedge clk) disable iff (!rstN)
    errDrop |-> $past(inValid && inReady && inTwo));

  a_r7_one_entry_per_tag: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  a_r8_full_blocks_new_tag: assert property (@(posedge clk) disable iff (!rstN)
    storeFull && inValid && inTwo && hitVec == '0 |-> !inReady);

  a_r9_hold_packet: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=>
      outValid && $stable(outTag) && $stable(outOp0) && $stable(outOp1) && $stable(outPair));

  a_r9_stall_blocks_input: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady);

endmodule

bind token_match_unit tmu_checker #(.DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(DEPTH)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .inTag    (inTag),
  .inTwo    (inTwo),
  .inData   (inData),
  .outValid (outValid),
  .outReady (outReady),
  .outTag   (outTag),
  .outOp0   (outOp0),
  .outOp1   (outOp1),
  .outPair  (outPair),
  .errDrop  (errDrop),
  .storeFull(storeFull),
  .hitVec   (hitVec)
);

// File: tb/tb_token_match_unit.sv
module tb_token_match_unit;

  localparam int DATA_W = 16;
  localparam int TAG_W  = 6;
  localparam int DEPTH  = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [TAG_W-1:0]  inTag = '0;
  logic              inPort = 1'b0;
  logic              inTwo = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic              outValid;
  logic              outReady = 1'b1;
  logic [TAG_W-1:0]  outTag;
  logic [DATA_W-1:0] outOp0;
  logic [DATA_W-1:0] outOp1;
  logic              outPair;
  logic              errDrop;

  always #10 clk = ~clk;

  token_match_unit #(.DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inReady(inReady), .inTag(inTag), .inPort(inPort),
    .inTwo(inTwo), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outTag(outTag),
    .outOp0(outOp0), .outOp1(outOp1), .outPair(outPair), .errDrop(errDrop)
  );

  typedef struct {
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] op0;
    logic [DATA_W-1:0] op1;
    logic              pair;
    string             req;
  } expPkt_t;

  expPkt_t expQ[$];
  int      nTests  = 0;
  int      nFailed = 0;
  int      errSeen = 0;
  bit      finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expectPkt(input logic [TAG_W-1:0] tag, input logic [DATA_W-1:0] op0,
                           input logic [DATA_W-1:0] op1, input logic pair, input string req);
    expPkt_t e;
    e.tag = tag; e.op0 = op0; e.op1 = op1; e.pair = pair; e.req = req;
    expQ.push_back(e);
  endtask

  // presents one token, waits for acceptance, checks the error pulse after the edge
  task automatic send(input logic [TAG_W-1:0] tag, input logic port, input logic two,
                      input logic [DATA_W-1:0] data, input logic expErr,
                      input string req, output int waits);
    @(negedge clk);
    inValid = 1'b1; inTag = tag; inPort = port; inTwo = two; inData = data;
    #1;
    waits = 0;
    while (!inReady) begin
      @(negedge clk); #1;
      waits++;
    end
    @(posedge clk); #1;
    inValid = 1'b0;
    check(errDrop == expErr, req, "errDrop after token", errDrop, expErr);
  endtask

  task automatic setReady(input logic v);
    @(posedge clk); #1;
    outReady = v;
  endtask

  // scoreboard monitor: a transfer happens at the edge after this sample
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (errDrop) errSeen++;
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R7", "unexpected packet tag", outTag, 0);
        end else begin
          expPkt_t e;
          e = expQ.pop_front();
          check(outTag == e.tag, e.req, "packet tag", outTag, e.tag);
          check(outOp0 == e.op0, e.req, "packet op0", outOp0, e.op0);
          check(outOp1 == e.op1, e.req, "packet op1", outOp1, e.op1);
          check(outPair == e.pair, e.req, "packet pair bit", outPair, e.pair);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFailed++;
      nTests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFailed);
      $finish;
    end
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
    check(errDrop == 1'b0, "R1", "errDrop in reset", errDrop, 0);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(inReady == 1'b1, "R1", "inReady after reset", inReady, 1);

    // R2 single-operand tokens, port bit ignored
    expectPkt(6'd3, 16'hAAAA, 16'h0, 1'b0, "R2");
    send(6'd3, 1'b1, 1'b0, 16'hAAAA, 1'b0, "R2", w);
    expectPkt(6'd4, 16'h1234, 16'h0, 1'b0, "R2");
    send(6'd4, 1'b0, 1'b0, 16'h1234, 1'b0, "R2", w);

    // R3 stored with no output, R4 match in both arrival orders
    send(6'd10, 1'b0, 1'b1, 16'h1111, 1'b0, "R3", w);
    check(outValid == 1'b0, "R3", "no packet for lone operand", outValid, 0);
    expectPkt(6'd10, 16'h1111, 16'h2222, 1'b1, "R4");
    send(6'd10, 1'b1, 1'b1, 16'h2222, 1'b0, "R4", w);
    send(6'd11, 1'b1, 1'b1, 16'h3333, 1'b0, "R4", w);
    expectPkt(6'd11, 16'h4444, 16'h3333, 1'b1, "R4");
    send(6'd11, 1'b0, 1'b1, 16'h4444, 1'b0, "R4", w);

    // R5 consumed entry: same tag waits again
    send(6'd10, 1'b0, 1'b1, 16'h5555, 1'b0, "R5", w);
    check(outValid == 1'b0, "R5", "reused tag does not refire", outValid, 0);
    expectPkt(6'd10, 16'h5555, 16'h6666, 1'b1, "R5");
    send(6'd10, 1'b1, 1'b1, 16'h6666, 1'b0, "R5", w);

    // R6 duplicate slot dropped and flagged, original kept
    send(6'd12, 1'b0, 1'b1, 16'h7777, 1'b0, "R6", w);
    send(6'd12, 1'b0, 1'b1, 16'h8888, 1'b1, "R6", w);
    check(outValid == 1'b0, "R6", "no packet for duplicate", outValid, 0);
    expectPkt(6'd12, 16'h7777, 16'h9999, 1'b1, "R6");
    send(6'd12, 1'b1, 1'b1, 16'h9999, 1'b0, "R6", w);
    @(negedge clk); #1;
    check(errDrop == 1'b0, "R6", "errDrop lasts one cycle", errDrop, 0);

    // R7 interleaved tags fire in completion order
    send(6'd20, 1'b0, 1'b1, 16'h00A0, 1'b0, "R7", w);
    send(6'd21, 1'b1, 1'b1, 16'h00B1, 1'b0, "R7", w);
    send(6'd22, 1'b0, 1'b1, 16'h00C0, 1'b0, "R7", w);
    expectPkt(6'd21, 16'h00D0, 16'h00B1, 1'b1, "R7");
    send(6'd21, 1'b0, 1'b1, 16'h00D0, 1'b0, "R7", w);
    expectPkt(6'd20, 16'h00A0, 16'h00E1, 1'b1, "R7");
    send(6'd20, 1'b1, 1'b1, 16'h00E1, 1'b0, "R7", w);
    expectPkt(6'd22, 16'h00C0, 16'h00F1, 1'b1, "R7");
    send(6'd22, 1'b1, 1'b1, 16'h00F1, 1'b0, "R7", w);

    // R8 capacity: fill all entries
    for (int i = 0; i < DEPTH; i++) begin
      send(6'(32 + i), 1'b0, 1'b1, 16'(16'h0200 + i), 1'b0, "R8", w);
    end
    @(negedge clk);
    inValid = 1'b1; inTag = 6'd60; inPort = 1'b0; inTwo = 1'b1; inData = 16'hBEEF;
    #1;
    check(inReady == 1'b0, "R8", "inReady for new tag when full", inReady, 0);
    @(negedge clk); #1;
    check(inReady == 1'b0, "R8", "inReady stays low when full", inReady, 0);
    inValid = 1'b0;
    expectPkt(6'd32, 16'h0200, 16'h0300, 1'b1, "R8");
    send(6'd32, 1'b1, 1'b1, 16'h0300, 1'b0, "R8", w);
    check(w == 0, "R8", "matching token waits when full", w, 0);
    send(6'd60, 1'b0, 1'b1, 16'hBEEF, 1'b0, "R8", w);
    check(w == 0, "R8", "new tag after a slot freed", w, 0);
    for (int i = 1; i < DEPTH; i++) begin
      expectPkt(6'(32 + i), 16'(16'h0200 + i), 16'(16'h0300 + i), 1'b1, "R8");
      send(6'(32 + i), 1'b1, 1'b1, 16'(16'h0300 + i), 1'b0, "R8", w);
    end
    expectPkt(6'd60, 16'hBEEF, 16'hCAFE, 1'b1, "R8");
    send(6'd60, 1'b1, 1'b1, 16'hCAFE, 1'b0, "R8", w);

    // R9 output stall
    setReady(1'b0);
    expectPkt(6'd7, 16'h0707, 16'h0, 1'b0, "R9");
    send(6'd7, 1'b0, 1'b0, 16'h0707, 1'b0, "R9", w);
    @(negedge clk);
    inValid = 1'b1; inTag = 6'd8; inPort = 1'b0; inTwo = 1'b0; inData = 16'h0808;
    #1;
    check(inReady == 1'b0, "R9", "inReady during stall", inReady, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check(outValid == 1'b1 && outTag == 6'd7 && outOp0 == 16'h0707, "R9",
            "held packet tag", outTag, 7);
    end
    inValid = 1'b0;
    setReady(1'b1);
    expectPkt(6'd8, 16'h0808, 16'h0, 1'b0, "R9");
    send(6'd8, 1'b0, 1'b0, 16'h0808, 1'b0, "R9", w);

    // R10 back-to-back acceptance
    for (int i = 0; i < 4; i++) begin
      expectPkt(6'(40 + i), 16'(16'h0A00 + i), 16'h0, 1'b0, "R10");
      send(6'(40 + i), 1'b0, 1'b0, 16'(16'h0A00 + i), 1'b0, "R10", w);
      check(w == 0, "R10", "wait cycles per token", w, 0);
    end

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R7", "packets still expected", expQ.size(), 0);
    check(errSeen == 1, "R6", "error pulses seen", errSeen, 1);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFailed);
    $finish;
  end

endmodule